// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a byte-wide storage array with an 8K-byte address space. The eight highest addresses are not storage. They hold a running time-of-day and calendar, plus one control byte. Software reaches both halves through the same synchronous port, using select, write enable, read enable, address and data. A read returns its byte one clock after the request. The lower part of the map behaves as ordinary scratch memory.

A one-second tick input advances the counters. Every field is kept in packed BCD. Hours run from 00 to 23. The date rolls over at the end of each month according to that month's length, and February of a leap year takes 29 days.

The control byte serves three purposes:
- It can halt counting so software can load a new time.
- It can freeze the bytes that reads return.
- It holds a signed calibration value that drops or adds a count once per 64-tick period.

A power-fail input deselects the port while it is asserted, but the clock keeps running.

Top module: `mmcal_top`

## Requirements
- R1: Addresses below 1FF8h act as read/write storage. The backing array has 2^STORE_AW bytes (1K by default), addressed by the low STORE_AW address bits, so 0405h aliases 0005h.
- R2: Seconds (1FF9h) and minutes (1FFAh) count 00 to 59 in packed BCD. A units digit of 9 carries into the tens digit, and 59 wraps to 00 with a carry into the next field.
- R3: Hours (1FFBh) count 00 to 23 and wrap to 00, advancing the date (1FFDh). Day of week (1FFCh) counts 1 to 7 and wraps to 1 on each date change.
- R4: April, June, September and November end after day 30, and the other months except February end after day 31. The date then returns to 01 and the month (1FFEh) advances. Month 12 wraps to 01 and increments the year (1FFFh). Year 99 wraps to 00.
- R5: February ends after day 29 when the BCD year is a multiple of four, including 00 (for example 00 and 12). Otherwise it ends after day 28.
- R6: Control byte 1FF8h, bit 7 (halt): while it is set, ticks do not advance the clock. Writes to 1FF9h through 1FFFh always load the counters directly, and counting resumes from the loaded values when bit 7 clears.
- R7: Control bit 6 (freeze): while it is set, reads of 1FF9h through 1FFFh return the values held when the bit was set, while the counters keep advancing. Clearing the bit exposes the live values.
- R8: Calibration uses control bits 4:0 as magnitude M and bit 5 as sign. Un-halted ticks form 64-tick periods numbered modulo 32 from zero after reset. On the 64th tick of a period numbered below M, a sign of 0 drops that tick, and a sign of 1 adds one extra second on the following cycle.
- R9: While pwr_fail is high, writes are ignored, reads return 00h, and the counters still advance on ticks.
- R10: Reset sets the clock to 00:00:00, day 1, date 01, month 01, year 00, and clears the control byte to 00h.
- R11: rdata is registered. It shows the addressed byte in the cycle after a read request (sel and rd_en high, wr_en low), reads of 1FF8h return the control byte, and rdata is 00h in any cycle not following such a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Port select |
| wr_en | input | 1 | Write strobe, qualified by sel |
| rd_en | input | 1 | Read strobe, qualified by sel |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | Power-fail deselect |

## Verification
The calendar is started from loaded values one second before a boundary and given a single tick. Each load isolates one carry path:
- a units-digit carry;
- an hour-digit carry;
- a 30-day month end;
- a year-end cascade;
- February in years 00, 01, 10 and 12, which separates the tens-parity leap rule from a plain binary test.

Calibration runs from reset through 128 ticks with drop and insert settings. This shows that only period zero is corrected when M is 1.

Halt, freeze and power-fail are each followed by ticks and reads. These reads separate a stopped counter from a frozen view and from a blocked bus.

// File: rtl/mmcal_pkg.sv
package mmcal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } cal_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   day: 8'h01, date: 8'h01, month: 8'h01,
                                   year: 8'h00};

    typedef enum logic [2:0] {
        SLOT_CTRL, SLOT_SEC, SLOT_MIN, SLOT_HOUR,
        SLOT_DAY, SLOT_DATE, SLOT_MONTH, SLOT_YEAR
    } slot_e;

    typedef struct packed {
        logic       halt;
        logic       freeze;
        logic       sign;
        logic [4:0] mag;
    } ctrl_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // tens digit parity is bit 4; an even tens digit needs units 0/4/8, odd needs 2/6
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic cal_t cal_next(input cal_t c);
        cal_t n = c;
        if (c.sec != 8'h59) n.sec = bcd_inc(c.sec);
        else begin
            n.sec = 8'h00;
            if (c.min != 8'h59) n.min = bcd_inc(c.min);
            else begin
                n.min = 8'h00;
                if (c.hour != 8'h23) n.hour = bcd_inc(c.hour);
                else begin
                    n.hour = 8'h00;
                    n.day  = (c.day >= 8'h07) ? 8'h01 : bcd_inc(c.day);
                    if (c.date != month_last(c.month, c.year)) n.date = bcd_inc(c.date);
                    else begin
                        n.date = 8'h01;
                        if (c.month != 8'h12) n.month = bcd_inc(c.month);
                        else begin
                            n.month = 8'h01;
                            n.year  = (c.year == 8'h99) ? 8'h00 : bcd_inc(c.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    function automatic logic [7:0] slot_byte(input cal_t c, input slot_e s);
        case (s)
            SLOT_SEC:   return c.sec;
            SLOT_MIN:   return c.min;
            SLOT_HOUR:  return c.hour;
            SLOT_DAY:   return c.day;
            SLOT_DATE:  return c.date;
            SLOT_MONTH: return c.month;
            SLOT_YEAR:  return c.year;
            default:    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cal_tick_gate.sv
module cal_tick_gate #(
    parameter int PERIOD = 64,
    parameter int MAG_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    input  logic             sign,
    input  logic [MAG_W-1:0] mag,
    output logic             adv
);
    localparam int TICK_W = $clog2(PERIOD);

    logic [TICK_W-1:0] tcnt;
    logic [MAG_W-1:0]  pcnt;
    logic              pend;
    logic              live, last, corr;

    assign live = tick && !halt;
    assign last = (tcnt == TICK_W'(PERIOD - 1));
    assign corr = last && (pcnt < mag);
    assign adv  = !halt && ((live && !(corr && !sign)) || pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
            pcnt <= '0;
            pend <= 1'b0;
        end else begin
            if (live) begin
                tcnt <= last ? '0 : tcnt + 1'b1;
                if (last) pcnt <= pcnt + 1'b1;
            end
            if (!halt) pend <= live && corr && sign;
        end
    end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import mmcal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       wr,
    input  slot_e      wr_slot,
    input  logic [7:0] wdata,
    output cal_t       now
);
    always_ff @(posedge clk) begin
        if (rst) now <= CAL_RESET;
        else if (wr) begin
            case (wr_slot)
                SLOT_SEC:   now.sec   <= wdata;
                SLOT_MIN:   now.min   <= wdata;
                SLOT_HOUR:  now.hour  <= wdata;
                SLOT_DAY:   now.day   <= wdata;
                SLOT_DATE:  now.date  <= wdata;
                SLOT_MONTH: now.month <= wdata;
                SLOT_YEAR:  now.year  <= wdata;
                default:    ;
            endcase
        end else if (adv) now <= cal_next(now);
    end
endmodule

// File: rtl/scratch_ram.sv
module scratch_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end
    assign rdata = mem[addr];
endmodule

// File: rtl/mmcal_top.sv
module mmcal_top
    import mmcal_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int STORE_AW = 10,
    parameter int PERIOD   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              sec_tick,
    input  logic              pwr_fail
);
    localparam int WIN_HI = ADDR_W - 3;

    ctrl_t      ctrl_q;
    cal_t       now, snap, view;
    slot_e      slot;
    logic       in_win, acc, wr, rd, cal_wr, ram_we, adv;
    logic [7:0] ram_q, rdata_q;
    logic       halt_w, freeze_w;

    assign slot     = slot_e'(addr[2:0]);
    assign in_win   = &addr[ADDR_W-1:3];
    assign acc      = sel && !pwr_fail;
    assign wr       = acc && wr_en;
    assign rd       = acc && rd_en && !wr_en;
    assign cal_wr   = wr && in_win && (slot != SLOT_CTRL);
    assign ram_we   = wr && !in_win;
    assign halt_w   = ctrl_q.halt;
    assign freeze_w = ctrl_q.freeze;
    assign view     = freeze_w ? snap : now;

    cal_tick_gate #(.PERIOD(PERIOD), .MAG_W(5)) u_gate (
        .clk(clk), .rst(rst), .tick(sec_tick), .halt(halt_w),
        .sign(ctrl_q.sign), .mag(ctrl_q.mag), .adv(adv)
    );

    cal_counter u_cnt (
        .clk(clk), .rst(rst), .adv(adv), .wr(cal_wr),
        .wr_slot(slot), .wdata(wdata), .now(now)
    );

    scratch_ram #(.AW(STORE_AW), .DW(8)) u_ram (
        .clk(clk), .we(ram_we), .addr(addr[STORE_AW-1:0]),
        .wdata(wdata), .rdata(ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            snap    <= CAL_RESET;
            rdata_q <= 8'h00;
        end else begin
            if (wr && in_win && slot == SLOT_CTRL) ctrl_q <= ctrl_t'(wdata);
            if (!freeze_w) snap <= now;
            if (!rd)                     rdata_q <= 8'h00;
            else if (!in_win)            rdata_q <= ram_q;
            else if (slot == SLOT_CTRL)  rdata_q <= ctrl_q;
            else                         rdata_q <= slot_byte(view, slot);
        end
    end

    assign rdata = rdata_q;
    if (WIN_HI < STORE_AW) begin : g_bad_cfg
        initial $error("STORE_AW must leave the clock window above storage");
    end
endmodule

// File: rtl/cal_chk.sv
module cal_chk
    import mmcal_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pwr_fail,
    input logic [7:0] rdata,
    input logic       adv,
    input logic       halt,
    input logic       freeze,
    input logic       cal_wr,
    input cal_t       now,
    input cal_t       view
);
    p_pf_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> rdata == 8'h00);

    p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (halt && !cal_wr) |=> $stable(now));

    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && !cal_wr && now.hour == 8'h23 && now.min == 8'h59 && now.sec == 8'h59)
        |=> (now.hour == 8'h00 && now.sec == 8'h00 && now.min == 8'h00));

    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
        freeze |=> (!freeze || $stable(view)));

    p_feb_end_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && !cal_wr && now.month == 8'h02 && now.date == 8'h28 &&
         now.hour == 8'h23 && now.min == 8'h59 && now.sec == 8'h59)
        |=> (now.date == (is_leap(now.year) ? 8'h29 : 8'h01)));
endmodule

bind mmcal_top cal_chk u_chk (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .rdata(rdata), .adv(adv),
    .halt(halt_w), .freeze(freeze_w), .cal_wr(cal_wr), .now(now), .view(view)
);

// File: tb/sim_mmcal_top.sv
module sim_mmcal_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        sec_tick = 1'b0, pwr_fail = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] got;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mmcal_top u0 (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .sec_tick(sec_tick), .pwr_fail(pwr_fail)
    );

    // {is_write, addr, data_or_expected}  (R1)
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 13'h0000, 8'h3C}, {1'b1, 13'h0001, 8'hC3},
        {1'b1, 13'h1FF7, 8'h5A}, {1'b1, 13'h03FF, 8'h99},
        {1'b0, 13'h0000, 8'h3C}, {1'b0, 13'h0001, 8'hC3},
        {1'b0, 13'h1FF7, 8'h5A}, {1'b0, 13'h03FF, 8'h99},
        {1'b1, 13'h0005, 8'hA5}, {1'b0, 13'h0405, 8'hA5}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [12:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, dy, dt, mo, y);
        wr(13'h1FF8, 8'h80);
        wr(13'h1FF9, s);  wr(13'h1FFA, mi); wr(13'h1FFB, h);
        wr(13'h1FFC, dy); wr(13'h1FFD, dt); wr(13'h1FFE, mo); wr(13'h1FFF, y);
        wr(13'h1FF8, 8'h00);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R10 reset state
        rdchk("R10 ctrl", 13'h1FF8, 8'h00);
        rdchk("R10 sec", 13'h1FF9, 8'h00);
        rdchk("R10 min", 13'h1FFA, 8'h00);
        rdchk("R10 hour", 13'h1FFB, 8'h00);
        rdchk("R10 day", 13'h1FFC, 8'h01);
        rdchk("R10 date", 13'h1FFD, 8'h01);
        rdchk("R10 month", 13'h1FFE, 8'h01);
        rdchk("R10 year", 13'h1FFF, 8'h00);

        // R1 vector walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][21]) wr(VEC[i][20:8], VEC[i][7:0]);
            else rdchk("R1 storage", VEC[i][20:8], VEC[i][7:0]);
        end

        // R11 idle output is zero after a read
        rd(13'h0000, got);
        @(negedge clk);
        check("R11 idle", rdata, 8'h00);

        // R2/R3/R4 year-end cascade
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick(1);
        rdchk("R2 sec 59", 13'h1FF9, 8'h59);
        tick(1);
        rdchk("R2 sec wrap", 13'h1FF9, 8'h00);
        rdchk("R2 min wrap", 13'h1FFA, 8'h00);
        rdchk("R3 hour wrap", 13'h1FFB, 8'h00);
        rdchk("R3 day wrap", 13'h1FFC, 8'h01);
        rdchk("R4 date wrap", 13'h1FFD, 8'h01);
        rdchk("R4 month wrap", 13'h1FFE, 8'h01);
        rdchk("R4 year wrap", 13'h1FFF, 8'h00);

        // R2 BCD units carry, R3 hour digit carry
        set_time(8'h09, 8'h12, 8'h10, 8'h03, 8'h15, 8'h06, 8'h05);
        tick(1);
        rdchk("R2 bcd 09->10", 13'h1FF9, 8'h10);
        set_time(8'h59, 8'h59, 8'h09, 8'h03, 8'h15, 8'h06, 8'h05);
        tick(1);
        rdchk("R3 hour 09->10", 13'h1FFB, 8'h10);

        // R4 30-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h05);
        tick(1);
        rdchk("R4 apr30 date", 13'h1FFD, 8'h01);
        rdchk("R4 apr30 month", 13'h1FFE, 8'h05);
        rdchk("R3 day step", 13'h1FFC, 8'h03);

        // R5 leap handling
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        tick(1);
        rdchk("R5 y00 feb29", 13'h1FFD, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00);
        tick(1);
        rdchk("R5 y00 mar", 13'h1FFE, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h01);
        tick(1);
        rdchk("R5 y01 date", 13'h1FFD, 8'h01);
        rdchk("R5 y01 month", 13'h1FFE, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12);
        tick(1);
        rdchk("R5 y12 feb29", 13'h1FFD, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
        tick(1);
        rdchk("R5 y10 month", 13'h1FFE, 8'h03);

        // R6 halt and load
        wr(13'h1FF8, 8'h80);
        wr(13'h1FF9, 8'h20);
        tick(3);
        rdchk("R6 halted", 13'h1FF9, 8'h20);
        wr(13'h1FF8, 8'h00);
        rdchk("R6 loaded", 13'h1FF9, 8'h20);
        tick(1);
        rdchk("R6 resume", 13'h1FF9, 8'h21);

        // R7 freeze
        wr(13'h1FF8, 8'h40);
        tick(2);
        rdchk("R7 frozen", 13'h1FF9, 8'h21);
        rdchk("R11 ctrl read", 13'h1FF8, 8'h40);
        wr(13'h1FF8, 8'h00);
        rdchk("R7 live", 13'h1FF9, 8'h23);

        // R9 power fail
        wr(13'h0010, 8'h6E);
        pwr_fail = 1'b1;
        wr(13'h0010, 8'h11);
        wr(13'h1FF9, 8'h45);
        rdchk("R9 read zero", 13'h0010, 8'h00);
        tick(1);
        pwr_fail = 1'b0;
        rdchk("R9 ram kept", 13'h0010, 8'h6E);
        rdchk("R9 sec ran", 13'h1FF9, 8'h24);

        // R8 calibration, drop
        do_reset();
        wr(13'h1FF8, 8'h01);
        tick(64);
        rdchk("R8 drop min", 13'h1FFA, 8'h01);
        rdchk("R8 drop sec", 13'h1FF9, 8'h03);
        tick(64);
        rdchk("R8 period1 min", 13'h1FFA, 8'h02);
        rdchk("R8 period1 sec", 13'h1FF9, 8'h07);
        // R8 insert
        do_reset();
        wr(13'h1FF8, 8'h21);
        tick(64);
        rdchk("R8 insert min", 13'h1FFA, 8'h01);
        rdchk("R8 insert sec", 13'h1FF9, 8'h05);
        // R8 zero magnitude
        do_reset();
        tick(64);
        rdchk("R8 none sec", 13'h1FF9, 8'h04);

        finish_run();
    end
endmodule